// File: doc/BRIEF.md
# Serial Flash 32KB Block Erase Command Decoder

This block is the target-side front end of a serial flash device for the 32KB block erase command. It watches the serial clock, the active-low chip select and the serial data input, all oversampled by a faster system clock, and assembles each frame bit by bit. A frame is one opcode byte and, for an erase, a 24-bit address sent most significant bit first. Data is taken on rising serial clock edges, so a host that idles the clock low and a host that idles it high are both served.

An erase starts only when every condition holds. The write-enable latch must be set. The addressed block must lie outside the guarded region. Chip select must rise exactly after the 32nd bit of the frame. When an erase starts, a busy flag is raised and a cycle counter, standing in for the erase time, runs down. The memory model then marks the whole block as blank (every byte 0xFF), and the busy flag and write-enable latch both drop. While the erase runs, the host can poll a status byte, and every other command is ignored.

The memory array is a behavioural model. It holds one blank flag per 32KB block, and it has a start strobe and a done pulse.

Top module: `spi_blk_erase_ctl`

## Requirements
- R1: The erase opcode is 0x52, followed by 24 address bits sent MSB first. The block index is address bits [15+BLK_W-1:15] (bits 17..15 by default), and all other address bits are ignored.
- R2: An erase frame is discarded when the write-enable latch is 0 at the moment chip select rises.
- R3: An erase starts only if chip select rises after exactly 32 rising clock edges in the frame. A frame of 31 or 33 bits is discarded, and the bit count returns to 0 once chip select is high.
- R4: When an accepted erase finishes, `blk_blank[b]` for the addressed block b goes to 1, meaning all 32K bytes read 0xFF. Blank flags reset to 0, never clear, and change only as an erase finishes.
- R5: BUSY is status bit 0. It is 1 from the chip select rise that starts an erase until the ERASE_CYCLES countdown ends, and then returns to 0.
- R6: The write-enable latch is status bit 1 and is cleared when an erase finishes.
- R7: Read status is opcode 0x05. After the opcode, the byte {6'b0, WEL, BUSY} is shifted out MSB first on `spi_miso`, one bit per falling clock edge, and it repeats. The command is served while BUSY is 1.
- R8: While BUSY is 1, erase and write-enable frames have no effect.
- R9: The guarded block count is 0, 1, 2 or 4 for `guard_size` values 0, 1, 2 and 3. With `guard_bottom`=0 the highest-numbered blocks are guarded, and with `guard_bottom`=1 the lowest-numbered blocks are. An erase of a guarded block is discarded.
- R10: Write enable is opcode 0x06. It sets the write-enable latch only when chip select rises after exactly 8 bits while BUSY is 0.
- R11: `spi_miso_oe` is 0 (output high-impedance) except during the data phase of a read-status frame. The erase works with the clock idling low or high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| guard_bottom | input | 1 | 1 guards the lowest blocks, 0 guards the highest |
| guard_size | input | 2 | Guarded block count code: 0, 1, 2 or 4 blocks |
| spi_miso | output | 1 | Serial data out (status byte) |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; 0 means high-impedance |
| blk_blank | output | 2**BLK_W | Per-block flag: 1 once the block has been erased to 0xFF |

## Verification
Assertions check the following on every cycle:
- An erase can only begin while the write-enable latch is set and the block is unguarded.
- BUSY holds until the erase engine reports completion, and the latch and BUSY both drop right after it.
- Blank flags change only on the done pulse and never clear.
- The bit count empties once chip select is high, and the output driver is off whenever chip select has been high for a cycle.

Only the bench scenarios can show other behaviour:
- A frame of 31 or 33 bits is refused.
- Upper address bits play no part in choosing the block.
- A second erase issued mid-erase is dropped.
- The status byte reads correctly while BUSY is 1.
- The guard table selects the right blocks in both directions and with either clock idle level.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  localparam logic [7:0] OP_ERASE32 = 8'h52;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RDSR    = 8'h05;

  typedef struct packed {
    logic wel;
    logic busy;
  } stat_t;
endpackage

// File: rtl/sbe_frame_rx.sv
module sbe_frame_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7,
  parameter int BLK_LSB     = 15,
  parameter int BLK_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  output logic             sel,
  output logic             sclk_rise,
  output logic             sclk_fall,
  output logic             cs_rise,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic [BLK_W-1:0] blk
);
  localparam int S = SYNC_STAGES;
  localparam logic [CNT_W-1:0] OP_BITS = CNT_W'(8);

  logic [S:0]   sclk_sr;
  logic [S:0]   cs_sr;
  logic [S-1:0] mosi_sr;
  logic         mosi_now;

  // input synchronisers; the extra stage on clock and select gives edges
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
    end else begin
      sclk_sr[0] <= sclk_i;
      cs_sr[0]   <= cs_n_i;
      mosi_sr[0] <= mosi_i;
      for (int i = 1; i <= S; i++) begin
        sclk_sr[i] <= sclk_sr[i-1];
        cs_sr[i]   <= cs_sr[i-1];
      end
      for (int i = 1; i < S; i++) mosi_sr[i] <= mosi_sr[i-1];
    end
  end

  assign mosi_now  = mosi_sr[S-1];
  assign sel       = ~cs_sr[S-1];
  assign cs_rise   = cs_sr[S-1] & ~cs_sr[S];
  assign sclk_rise = sclk_sr[S-1] & ~sclk_sr[S];
  assign sclk_fall = ~sclk_sr[S-1] & sclk_sr[S];

  // bit counter saturates so an over-long frame never aliases to 32
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt <= '0;
    end else if (sclk_rise && (bit_cnt != '1)) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode <= '0;
    end else if (sel && sclk_rise && (bit_cnt < OP_BITS)) begin
      opcode <= {opcode[6:0], mosi_now};
    end
  end

  // frame bit c carries address bit 31-c; keep only the block index bits
  for (genvar b = 0; b < BLK_W; b++) begin : g_blk
    localparam logic [CNT_W-1:0] POS = CNT_W'(31 - BLK_LSB - b);
    always_ff @(posedge clk) begin
      if (rst) begin
        blk[b] <= 1'b0;
      end else if (sel && sclk_rise && (bit_cnt == POS)) begin
        blk[b] <= mosi_now;
      end
    end
  end

  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (bit_cnt == '0));
endmodule

// File: rtl/sbe_guard.sv
module sbe_guard #(
  parameter int BLK_W = 3
) (
  input  logic [BLK_W-1:0] blk,
  input  logic             guard_bottom,
  input  logic [1:0]       guard_size,
  output logic             hit
);
  localparam int NBLK = 1 << BLK_W;

  int span;
  int bi;

  always_comb begin
    bi   = int'(blk);
    span = (guard_size == 2'd0) ? 0 : (1 << (int'(guard_size) - 1));
    if (guard_bottom) hit = (bi < span);
    else              hit = (bi >= (NBLK - span));
  end
endmodule

// File: rtl/sbe_erase_engine.sv
module sbe_erase_engine #(
  parameter int BLK_W        = 3,
  parameter int ERASE_CYCLES = 4096
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [BLK_W-1:0]      start_blk,
  output logic                  done,
  output logic [(1<<BLK_W)-1:0] blank_map
);
  localparam int NBLK = 1 << BLK_W;
  localparam int TW   = $clog2(ERASE_CYCLES + 1);

  logic [TW-1:0]    remain;
  logic             running;
  logic [BLK_W-1:0] tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      running <= 1'b0;
      tgt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        running <= 1'b1;
        remain  <= TW'(ERASE_CYCLES - 1);
        tgt     <= start_blk;
      end else if (running) begin
        if (remain == '0) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  // array model: one blank flag per block, single write port
  always_ff @(posedge clk) begin
    if (rst) begin
      blank_map <= '0;
    end else if (running && (remain == '0)) begin
      blank_map[tgt] <= 1'b1;
    end
  end

  p_blank_on_done_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(blank_map) |-> done);
  p_blank_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (($past(blank_map) & ~blank_map) == '0));
  p_single_run_r8: assert property (@(posedge clk) disable iff (rst)
    (start |-> !running));
  // NBLK kept for readers sizing the map
  initial begin
    if (NBLK < 2) $display("erase engine configured with a single block");
  end
endmodule

// File: rtl/spi_blk_erase_ctl.sv
module spi_blk_erase_ctl
  import sbe_pkg::*;
#(
  parameter int BLK_W        = 3,
  parameter int ERASE_CYCLES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  input  logic                  guard_bottom,
  input  logic [1:0]            guard_size,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  output logic [(1<<BLK_W)-1:0] blk_blank
);
  localparam int CNT_W   = 7;
  localparam int BLK_LSB = 15;
  localparam logic [CNT_W-1:0] ERASE_BITS = CNT_W'(32);
  localparam logic [CNT_W-1:0] OP_BITS    = CNT_W'(8);

  logic             sel, sclk_rise, sclk_fall, cs_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       opcode;
  logic [BLK_W-1:0] blk;
  logic             guard_hit;
  logic             eng_done;
  logic             erase_go, wren_go, rdsr_phase;
  stat_t            stat_q;
  logic [7:0]       stat_byte;

  sbe_frame_rx #(
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .BLK_LSB(BLK_LSB), .BLK_W(BLK_W)
  ) u_rx (
    .clk(clk), .rst(rst), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sel(sel), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
    .bit_cnt(bit_cnt), .opcode(opcode), .blk(blk)
  );

  sbe_guard #(.BLK_W(BLK_W)) u_guard (
    .blk(blk), .guard_bottom(guard_bottom), .guard_size(guard_size), .hit(guard_hit)
  );

  // commit decisions are taken in the cycle chip select is seen rising
  assign erase_go = cs_rise && (opcode == OP_ERASE32) && (bit_cnt == ERASE_BITS)
                    && stat_q.wel && !stat_q.busy && !guard_hit;
  assign wren_go  = cs_rise && (opcode == OP_WREN) && (bit_cnt == OP_BITS)
                    && !stat_q.busy;

  sbe_erase_engine #(.BLK_W(BLK_W), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .start(erase_go), .start_blk(blk),
    .done(eng_done), .blank_map(blk_blank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      if (eng_done) begin
        stat_q.busy <= 1'b0;
        stat_q.wel  <= 1'b0;
      end else begin
        if (erase_go) stat_q.busy <= 1'b1;
        if (wren_go)  stat_q.wel  <= 1'b1;
      end
    end
  end

  assign stat_byte  = {6'b0, stat_q.wel, stat_q.busy};
  assign rdsr_phase = (opcode == OP_RDSR) && (bit_cnt >= OP_BITS);

  // status shifts out on falling clock edges after the opcode byte
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else if (sclk_fall && rdsr_phase) begin
      spi_miso_oe <= 1'b1;
      spi_miso    <= stat_byte[~bit_cnt[2:0]];
    end
  end

  p_busy_needs_wel_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q.busy) |-> $past(stat_q.wel));
  p_unguarded_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q.busy) |-> !$past(guard_hit));
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_q.busy && !eng_done) |=> stat_q.busy);
  p_wel_drop_r6: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> (!stat_q.wel && !stat_q.busy));
  p_oe_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!sel && !$past(sel)) |-> !spi_miso_oe);
endmodule

// File: tb/spi_blk_erase_ctl_test.sv
module spi_blk_erase_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int ERASE_CYC  = 1000;
  localparam int BW         = 3;
  localparam int NB         = 1 << BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic guard_bottom = 1'b0;
  logic [1:0] guard_size = 2'd0;
  logic miso, oe;
  logic [NB-1:0] blank;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [NB-1:0] exp_blank = '0;
  bit pending = 0, rdsr_win = 0, exp_wel = 0, running = 0;
  int pend_blk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_blk_erase_ctl #(.BLK_W(BW), .ERASE_CYCLES(ERASE_CYC), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .guard_bottom(guard_bottom), .guard_size(guard_size),
    .spi_miso(miso), .spi_miso_oe(oe), .blk_blank(blank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit guarded(input int b);
    int span;
    case (guard_size)
      2'd0: span = 0;
      2'd1: span = 1;
      2'd2: span = 2;
      default: span = 4;
    endcase
    if (guard_bottom) return b < span;
    return b >= NB - span;
  endfunction

  task automatic frame(input logic [31:0] data, input int nbits, input bit m3,
                       output logic [7:0] rx);
    rx = '0;
    sclk = m3;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = data[31-i];
      wait_clk(HALF);
      rx = {rx[6:0], miso};
      sclk = 1'b1;
      wait_clk(HALF);
    end
    if (!m3) begin
      sclk = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(12);
  endtask

  task automatic rdsr(input bit m3, output logic [7:0] st);
    rdsr_win = 1;
    frame({8'h05, 24'h0}, 16, m3, st);
    rdsr_win = 0;
  endtask

  task automatic wren(input bit m3, input int nbits);
    logic [7:0] rx;
    frame({8'h06, 24'h0}, nbits, m3, rx);
    if (!pending && nbits == 8) exp_wel = 1;
  endtask

  task automatic erase(input logic [23:0] addr, input int nbits, input bit m3);
    logic [7:0] rx;
    int b;
    b = int'(addr[17:15]);
    frame({8'h52, addr}, nbits, m3, rx);
    if (!pending && nbits == 32 && exp_wel && !guarded(b)) begin
      pending  = 1;
      pend_blk = b;
    end
  endtask

  task automatic finish_erase(input bit m3);
    logic [7:0] st;
    int polls = 0;
    rdsr(m3, st);
    chk("R5 busy set after commit", {31'b0, st[0]}, 32'd1);
    while (st[0] === 1'b1 && polls < 40) begin
      chk("R7 status during erase", {24'b0, st}, 32'h03);
      rdsr(m3, st);
      polls++;
    end
    chk("R6 status after erase", {24'b0, st}, 32'h00);
    exp_blank[pend_blk] = 1'b1;
    pending = 0;
    exp_wel = 0;
    chk("R4 block blank", {24'b0, blank}, {24'b0, exp_blank});
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (running) begin
      if (!pending) chk("R4 blank map", {24'b0, blank}, {24'b0, exp_blank});
      if (!rdsr_win) chk("R11 output enable", {31'b0, oe}, 32'd0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    running = 1;
    chk("R11 reset oe", {31'b0, oe}, 32'd0);
    chk("R4 reset blank", {24'b0, blank}, 32'd0);
    rdsr(0, st);
    chk("R7 reset status", {24'b0, st}, 32'h00);

    erase(24'hF08ABC, 32, 0);
    rdsr(0, st);
    chk("R2 erase without WEL", {24'b0, st}, 32'h00);

    wren(0, 9);
    rdsr(0, st);
    chk("R10 nine-bit write enable ignored", {24'b0, st}, 32'h00);
    wren(0, 8);
    rdsr(0, st);
    chk("R10 write enable sets WEL", {24'b0, st}, 32'h02);

    erase(24'hF08ABC, 31, 0);
    rdsr(0, st);
    chk("R3 31-bit erase discarded", {24'b0, st}, 32'h02);
    erase(24'hF08ABC, 33, 0);
    rdsr(0, st);
    chk("R3 33-bit erase discarded", {24'b0, st}, 32'h02);

    // upper address bits set; block index bits 17..15 = 1
    erase(24'hF08ABC, 32, 0);
    chk("R1 erase committed", {31'b0, pending}, 32'd1);
    finish_erase(0);
    chk("R1 block 1 only", {24'b0, blank}, 32'h02);

    // second erase while busy is dropped
    wren(0, 8);
    erase(24'h018000, 32, 0);
    erase(24'h030000, 32, 0);
    wren(0, 8);
    finish_erase(0);
    chk("R8 erase during busy ignored", {24'b0, blank}, 32'h0A);
    rdsr(0, st);
    chk("R8 write enable during busy ignored", {24'b0, st}, 32'h00);

    // guarding, clock idle high
    guard_bottom = 1'b0;
    guard_size   = 2'd2;
    wren(1, 8);
    erase(24'h038000, 32, 1);
    rdsr(1, st);
    chk("R9 top-guarded block refused", {24'b0, st}, 32'h02);
    guard_bottom = 1'b1;
    guard_size   = 2'd1;
    erase(24'h000000, 32, 1);
    rdsr(1, st);
    chk("R9 bottom-guarded block refused", {24'b0, st}, 32'h02);
    erase(24'h030000, 32, 1);
    chk("R9 unguarded block accepted", {31'b0, pending}, 32'd1);
    finish_erase(1);
    chk("R11 erase with idle-high clock", {24'b0, blank}, 32'h4A);

    guard_bottom = 1'b1;
    guard_size   = 2'd3;
    wren(1, 8);
    erase(24'h018000, 32, 1);
    rdsr(1, st);
    chk("R9 four bottom blocks guarded", {24'b0, st}, 32'h02);

    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule